// File: doc/BRIEF.md
# MDIO Single-Command Management Controller

This block is a register-driven management master for Ethernet PHYs. Software loads an optional write value into a data register and then writes one command word that names the operation, the PHY address and the PHY register number. The controller answers by serializing one Clause 22 management frame on the MDC/MDIO pair. While the frame runs it shows a busy flag, and it clears that flag by itself at the end of the frame.

For read operations the controller releases MDIO from the turnaround onward. It samples the PHY's reply on the rising MDC edges and places the 16-bit result in the upper half of the data register. A separate status flag tells software whether the PHY actually drove the turnaround low, that is, whether the returned value can be trusted. MDC is produced from the system clock by a parameterized divider and toggles only while a frame is in flight.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command register reads 0, the status register reads 0, MDC is low and MDIO is released (mdio_oe low).
- R2: Register word addresses are 0 for command, 1 for data, 2 for status, and 3 reads as 0. In the command word, bit 20 is busy, bit 17 is read, bit 16 is write, bits 12:8 are the PHY address and bits 4:0 are the register number. A command write made while idle, with bit 20 set and exactly one of bits 17 and 16 set, starts a frame. Read-back of the command register returns the accepted fields, with bit 20 showing whether a frame is in flight.
- R3: A command write made while idle that lacks bit 20, or that sets neither or both of bits 17 and 16, starts no frame and leaves busy clear.
- R4: A command write made while busy is ignored. The frame in flight is unchanged, no extra frame follows, and the command read-back keeps the earlier fields.
- R5: The frame is 64 bits, sent MSB first, in this order: 32 ones, start 01, opcode 10 (read) or 01 (write), the 5-bit PHY address, the 5-bit register number, turnaround 10 (write only), and then data[15:0] of the data register (write only).
- R6: MDC is low when idle and has a period of 2*HALF_DIV system clocks during a frame. Busy reads 1 up to and including the cycle before the edge 128*HALF_DIV clocks after the edge that accepted the command, and reads 0 from that edge on. MDIO changes only together with an MDC falling edge.
- R7: On a write, mdio_oe is high for all 64 bit times. On a read, it is high for bit times 0 to 45 and low from bit 46 (first turnaround bit) to the end. When idle it is low.
- R8: On read completion, the 16 bits sampled on the rising MDC edges of bit times 48 to 63 are written into data[31:16], first-sampled bit in bit 31, and data[15:0] is kept. An undriven (pulled-up) line yields 16'hFFFF.
- R9: Status bit 0 (reply missing) is set at read completion when the sample of bit time 47 was 1, and cleared at read completion otherwise. It is cleared when any command is accepted, and a write completion leaves it at 0.
- R10: When a software write to the data register falls in the same cycle as a read completion, data[15:0] takes the software value and data[31:16] takes the captured reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
Two things can land on one clock edge: the read completion that loads the reply into the upper half of the data register, and a software write to that same register. The bench counts the exact edge from the edge that accepted the read command (128*HALF_DIV clocks later) and places the data-register write on it. It then expects a merged word, with the captured reply in the upper half and the software value in the lower half. The same edge count also pins down the busy drop, and a scoreboard compares every frame bit and output-enable bit against the value the driver predicted.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    localparam int FRAME_BITS = 64;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;

    localparam int TA_FIRST   = 46;
    localparam int TA_SECOND  = 47;
    localparam int DATA_FIRST = 48;
    localparam int LAST_POS   = FRAME_BITS - 1;

    localparam int CMD_BUSY_BIT  = 20;
    localparam int CMD_READ_BIT  = 17;
    localparam int CMD_WRITE_BIT = 16;
    localparam int CMD_PHY_LSB   = 8;
    localparam int CMD_REG_LSB   = 0;

    typedef enum logic [1:0] {
        SEL_CMD    = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                  active;
        logic                  is_read;
        logic [POS_W-1:0]      pos;
        logic [FRAME_BITS-1:0] sh;
        logic                  ta_ok;
        logic [DATA_W-1:0]     cap;
    } eng_state_t;

    typedef struct packed {
        logic              op_rd;
        logic              op_wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [31:0]       data;
        logic              inv;
    } ctrl_state_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              rd,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regn,
        input logic [DATA_W-1:0] wval
    );
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] dv;
        op = rd ? 2'b10 : 2'b01;
        ta = rd ? 2'b00 : 2'b10;
        dv = rd ? '0 : wval;
        return {{32{1'b1}}, 2'b01, op, phy, regn, ta, dv};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_state_t;

    div_state_t div_d, div_q;
    logic       wrap;

    always_comb begin
        div_d = div_q;
        wrap  = en && (div_q.cnt == CNT_MAX);
        if (!en) begin
            div_d.cnt = '0;
            div_d.mdc = 1'b0;
        end else if (wrap) begin
            div_d.cnt = '0;
            div_d.mdc = ~div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign mdc      = div_q.mdc;
    assign rise_stb = wrap && !div_q.mdc;
    assign fall_stb = wrap &&  div_q.mdc;

    assert_mdc_idle_low_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        !en |=> !mdc
    );

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_read,
    input  logic [FRAME_BITS-1:0] start_frame,
    input  logic                  rise_stb,
    input  logic                  fall_stb,
    input  logic                  mdio_i,
    output logic                  active,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_ok
);
    eng_state_t eng_d, eng_q;
    logic       at_last;

    always_comb begin
        eng_d   = eng_q;
        at_last = (eng_q.pos == POS_W'(LAST_POS));
        if (start) begin
            eng_d.active  = 1'b1;
            eng_d.is_read = start_read;
            eng_d.pos     = '0;
            eng_d.sh      = start_frame;
            eng_d.ta_ok   = 1'b0;
            eng_d.cap     = '0;
        end else if (eng_q.active) begin
            if (rise_stb && eng_q.is_read) begin
                if (eng_q.pos == POS_W'(TA_SECOND)) begin
                    eng_d.ta_ok = !mdio_i;
                end
                if (eng_q.pos >= POS_W'(DATA_FIRST)) begin
                    eng_d.cap = {eng_q.cap[DATA_W-2:0], mdio_i};
                end
            end
            if (fall_stb) begin
                if (at_last) begin
                    eng_d.active = 1'b0;
                end else begin
                    eng_d.pos = eng_q.pos + 1'b1;
                    eng_d.sh  = {eng_q.sh[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign active  = eng_q.active;
    assign done    = eng_q.active && fall_stb && at_last;
    assign mdio_o  = eng_q.active ? eng_q.sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = eng_q.active &&
                     (!eng_q.is_read || (eng_q.pos < POS_W'(TA_FIRST)));
    assign rd_data = eng_q.cap;
    assign rd_ok   = eng_q.ta_ok;

    assert_mdio_only_on_fall_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (eng_q.active && !fall_stb && !start) |=> $stable(mdio_o)
    );

    assert_read_released_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (eng_q.active && eng_q.is_read && fall_stb &&
         eng_q.pos == POS_W'(TA_FIRST - 1)) |=> !mdio_oe
    );

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_cmd_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    ctrl_state_t           ctl_d, ctl_q;
    logic                  busy;
    logic                  done;
    logic                  rise_stb;
    logic                  fall_stb;
    logic                  rd_ok;
    logic [DATA_W-1:0]     rd_data;
    logic                  cmd_wr;
    logic                  cmd_legal;
    logic                  start;
    logic [FRAME_BITS-1:0] start_frame;

    mdio_clk_div #(
        .HALF_DIV (HALF_DIV)
    ) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine i_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_read  (reg_wdata[CMD_READ_BIT]),
        .start_frame (start_frame),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .mdio_i      (mdio_i),
        .active      (busy),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .done        (done),
        .rd_data     (rd_data),
        .rd_ok       (rd_ok)
    );

    always_comb begin
        ctl_d       = ctl_q;
        cmd_wr      = reg_wr && (reg_sel_e'(reg_addr) == SEL_CMD);
        cmd_legal   = reg_wdata[CMD_BUSY_BIT] &&
                      (reg_wdata[CMD_READ_BIT] ^ reg_wdata[CMD_WRITE_BIT]);
        start       = cmd_wr && cmd_legal && !busy;
        start_frame = build_frame(reg_wdata[CMD_READ_BIT],
                                  reg_wdata[CMD_PHY_LSB +: ADDR_W],
                                  reg_wdata[CMD_REG_LSB +: ADDR_W],
                                  ctl_q.data[DATA_W-1:0]);
        if (start) begin
            ctl_d.op_rd = reg_wdata[CMD_READ_BIT];
            ctl_d.op_wr = reg_wdata[CMD_WRITE_BIT];
            ctl_d.phy   = reg_wdata[CMD_PHY_LSB +: ADDR_W];
            ctl_d.regn  = reg_wdata[CMD_REG_LSB +: ADDR_W];
            ctl_d.inv   = 1'b0;
        end
        if (reg_wr && (reg_sel_e'(reg_addr) == SEL_DATA)) begin
            ctl_d.data = reg_wdata;
        end
        if (done && ctl_q.op_rd) begin
            ctl_d.data[31:16] = rd_data;
            ctl_d.inv         = !rd_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            SEL_CMD:    reg_rdata = {11'd0, busy, 2'd0, ctl_q.op_rd, ctl_q.op_wr,
                                     3'd0, ctl_q.phy, 3'd0, ctl_q.regn};
            SEL_DATA:   reg_rdata = ctl_q.data;
            SEL_STATUS: reg_rdata = {31'd0, ctl_q.inv};
            default:    reg_rdata = '0;
        endcase
    end

    assert_illegal_ignored_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !cmd_legal) |=> !busy
    );

    assert_busy_cmd_ignored_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && !done) |=> (busy && $stable(ctl_q.phy) && $stable(ctl_q.regn))
    );

    assert_accept_clears_flag_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        start |=> (busy && !ctl_q.inv)
    );

    assert_write_keeps_flag_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (done && ctl_q.op_wr) |=> !ctl_q.inv
    );

endmodule

// File: tb/test_mdio_cmd_ctrl.sv
module test_mdio_cmd_ctrl;
    localparam int H     = 4;
    localparam int FRAME = 128 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int          n_vec = 0;
    int          n_bad = 0;
    int          frames_seen = 0;
    int          bitpos = 0;
    logic        phy_en = 1'b0;
    logic [15:0] phy_data = '0;
    logic [63:0] exp_bits[$];
    logic [63:0] exp_oe[$];
    logic [63:0] cur_bits = '0;
    logic [63:0] cur_oe = '0;
    logic        finished = 1'b0;

    always #10 clk = ~clk;

    mdio_cmd_ctrl #(.HALF_DIV(H)) i_mdio_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    assign mdio_i = mdio_oe ? mdio_o :
                    (phy_en && bitpos == 47) ? 1'b0 :
                    (phy_en && bitpos >= 48) ? phy_data[63 - bitpos] : 1'b1;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops the predicted frame and compares as bits arrive
    always @(posedge mdc) begin
        cur_bits = {cur_bits[62:0], mdio_o};
        cur_oe   = {cur_oe[62:0], mdio_oe};
        bitpos   = bitpos + 1;
        if (bitpos == 64) begin
            bitpos = 0;
            frames_seen++;
            n_vec++;
            if (exp_bits.size() == 0) begin
                n_bad++;
                $display("FAIL R4 unexpected frame: got %h expected none", cur_bits);
            end else begin
                logic [63:0] eb, eo;
                eb = exp_bits.pop_front();
                eo = exp_oe.pop_front();
                if (cur_oe !== eo) begin
                    n_bad++;
                    $display("FAIL R7 oe mask: got %h expected %h", cur_oe, eo);
                end else if ((cur_bits & eo) !== (eb & eo)) begin
                    n_bad++;
                    $display("FAIL R5 frame bits: got %h expected %h", cur_bits & eo, eb & eo);
                end
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // driver: pushes the predicted frame, then issues the command
    task automatic issue(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wv);
        exp_bits.push_back({32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
                            rd ? 2'b00 : 2'b10, rd ? 16'h0 : wv});
        exp_oe.push_back(rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF);
        reg_write(2'd0, (32'd1 << 20) | (rd ? (32'd1 << 17) : (32'd1 << 16)) |
                        ({27'd0, phy} << 8) | {27'd0, rg});
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        v = 32'hFFFF_FFFF;
        while (v[20]) reg_read(2'd0, v);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int          f0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, v); chk("R1 cmd after reset", v, 32'h0);
        reg_read(2'd2, v); chk("R1 status after reset", v, 32'h0);
        chk("R1 mdc/oe after reset", {30'd0, mdc, mdio_oe}, 32'h0);
        reg_read(2'd3, v); chk("R2 unused address", v, 32'h0);

        // R5 R6 write frame with exact busy timing
        reg_write(2'd1, 32'h0000_A5C3);
        issue(1'b0, 5'd5, 5'h1A, 16'hA5C3);
        reg_addr = 2'd0;
        #1 chk("R2 readback while busy", reg_rdata, 32'h0011_051A);
        repeat (FRAME - 1) @(posedge clk);
        @(negedge clk);
        chk("R6 busy before last edge", {31'd0, reg_rdata[20]}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R6 busy drops on last edge", {31'd0, reg_rdata[20]}, 32'd0);
        chk("R2 readback after done", reg_rdata, 32'h0001_051A);
        repeat (3 * H) @(negedge clk);
        chk("R6 mdc idle low", {31'd0, mdc}, 32'd0);
        chk("R7 oe idle low", {31'd0, mdio_oe}, 32'd0);

        // R5 boundary field values
        reg_write(2'd1, 32'h0000_FFFF);
        issue(1'b0, 5'd31, 5'd31, 16'hFFFF);
        wait_idle();
        reg_write(2'd1, 32'h0000_0000);
        issue(1'b0, 5'd0, 5'd0, 16'h0000);
        wait_idle();

        // R8 R9 read with PHY answering
        reg_write(2'd1, 32'h0000_A5C3);
        phy_en = 1'b1; phy_data = 16'h3C96;
        issue(1'b1, 5'h11, 5'd3, 16'h0);
        wait_idle();
        reg_read(2'd1, v); chk("R8 read data merge", v, 32'h3C96_A5C3);
        reg_read(2'd2, v); chk("R9 flag clear on answer", v, 32'h0);

        // R8 R9 read without answer
        phy_en = 1'b0;
        issue(1'b1, 5'h02, 5'h1F, 16'h0);
        wait_idle();
        reg_read(2'd1, v); chk("R8 undriven reads ones", v, 32'hFFFF_A5C3);
        reg_read(2'd2, v); chk("R9 flag set on no answer", v, 32'h1);
        issue(1'b0, 5'h02, 5'h04, 16'hA5C3);
        reg_read(2'd2, v); chk("R9 flag cleared on accept", v, 32'h0);
        wait_idle();
        reg_read(2'd2, v); chk("R9 write completion keeps 0", v, 32'h0);

        // R4 command while busy
        f0 = frames_seen;
        issue(1'b0, 5'h07, 5'h09, 16'hA5C3);
        repeat (40) @(posedge clk);
        reg_write(2'd0, 32'h0012_1F1F);
        reg_read(2'd0, v); chk("R4 readback kept", v, 32'h0011_0709);
        wait_idle();
        repeat (4 * FRAME) @(posedge clk);
        chk("R4 single frame", frames_seen - f0, 32'd1);

        // R3 illegal commands
        f0 = frames_seen;
        reg_write(2'd0, 32'h0013_0101);
        reg_read(2'd0, v); chk("R3 both op bits", {31'd0, v[20]}, 32'd0);
        reg_write(2'd0, 32'h0010_0101);
        reg_read(2'd0, v); chk("R3 no op bits", {31'd0, v[20]}, 32'd0);
        reg_write(2'd0, 32'h0002_0101);
        reg_read(2'd0, v); chk("R3 no busy bit", {31'd0, v[20]}, 32'd0);
        repeat (2 * FRAME) @(posedge clk);
        chk("R3 no frame sent", frames_seen - f0, 32'd0);
        chk("R3 mdc stays low", {31'd0, mdc}, 32'd0);

        // R10 data write in the completion cycle
        phy_en = 1'b1; phy_data = 16'h5AF0;
        issue(1'b1, 5'h03, 5'h01, 16'h0);
        repeat (FRAME - 1) @(posedge clk);
        reg_write(2'd1, 32'h1234_8765);
        reg_read(2'd0, v); chk("R10 done on that edge", {31'd0, v[20]}, 32'd0);
        reg_read(2'd1, v); chk("R10 collision merge", v, 32'h5AF0_8765);
        reg_read(2'd2, v); chk("R10 flag clear", v, 32'h0);

        repeat (4 * H) @(posedge clk);
        chk("R5 scoreboard drained", exp_bits.size(), 32'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule